// File: doc/BRIEF.md
# Two-Way Host/Engine Message Mailbox

This block carries short messages between a host processor and a packet engine. Each direction has its own FIFO. The host sees four word-wide registers: a data port, a status word, a control word and a mailbox word. A host write to the data port pushes into the inbound FIFO (host to engine), and a host read from the same address pops the outbound FIFO (engine to host). On its side, the engine pops the inbound FIFO and pushes into the outbound FIFO.

The block also contains a sequencer that moves a whole two-word message without host software polling the status word. It has three operations. A send refuses to start when the inbound FIFO already holds data. Otherwise it pushes both words and waits for the engine to drain them. A receive collects two words from the outbound FIFO. An exchange does a send and then a receive, and requires the reply to match the sent pair. Every wait is bounded by a polling limit. A poll interval is `POLL_CYCLES` clocks, and the limit is `MAX_POLLS` intervals.

Host register addresses are: 0 data port, 1 status, 2 control, 3 mailbox. Sequencer op codes are: 0 send, 1 receive, 2 exchange (3 acts as send). Result codes are: 0 success, 1 I/O error, 2 timeout.

Top module: `msg_mailbox`

## Requirements
- R1: After reset the status word reads 0x00060000, the control word reads 0x00030000, the mailbox word reads 0x0000F0F0, and the sequencer is idle.
- R2: Each FIFO is first-in first-out with `DEPTH` words (default 4). Host data-port writes reach the engine pop port in order, and engine pushes reach host data-port reads in order.
- R3: A push into a full FIFO or a pop from an empty FIFO is ignored. A host data read of an empty outbound FIFO returns 0.
- R4: Status bit 16 is set when the outbound FIFO is not empty, bit 17 when the inbound FIFO is not full, bit 18 when the outbound FIFO is not full, and bit 19 when the inbound FIFO is not empty. Bit 23 always reads 0, and all bits outside 16..23 read 0.
- R5: Control bits 16 and 24 each enable outbound pushes, and bits 17 and 25 each enable inbound pushes. When both enable bits of a FIFO are clear, pushes into it are ignored. Only these four bits are stored and read back.
- R6: A host write to the mailbox address stores data bits 15:0. Status bit 20 is set when some bit of mailbox[7:0] is set and the matching bit of mailbox[15:8] is clear.
- R7: Status bit 21 equals control bit 25 AND inbound empty. Status bit 22 equals control bit 24 AND outbound not empty.
- R8: A send or exchange that starts while the inbound FIFO is not empty ends with an I/O error and pushes nothing.
- R9: A send pushes word0 and then word1. It ends with success once the engine has emptied the inbound FIFO, and `seqDone` pulses for exactly one cycle.
- R10: If the inbound FIFO does not empty, a send ends with a timeout after `POLL_CYCLES*MAX_POLLS` waiting cycles.
- R11: A receive pops two outbound words into `seqRx0`/`seqRx1` and ends with success. Only cycles with an empty outbound FIFO count toward its timeout, which has the same limit as R10.
- R12: An exchange ends with success when the reply equals the sent pair word for word. Otherwise it ends with an I/O error.
- R13: While the sequencer is busy, host data-port writes and reads are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostRdEn | input | 1 | Host register read strobe (pops on the data port) |
| hostAddr | input | 2 | Host register select |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data for the selected register |
| engPopEn | input | 1 | Engine pop of the inbound FIFO |
| engPopData | output | 32 | Head word of the inbound FIFO |
| engInEmpty | output | 1 | Inbound FIFO empty |
| engPushEn | input | 1 | Engine push into the outbound FIFO |
| engPushData | input | 32 | Engine push data |
| engOutFull | output | 1 | Outbound FIFO full |
| seqStart | input | 1 | Start a sequencer operation (taken when idle) |
| seqOp | input | 2 | Sequencer operation |
| seqWord0 | input | 32 | First message word to send |
| seqWord1 | input | 32 | Second message word to send |
| seqBusy | output | 1 | Sequencer operation in progress |
| seqDone | output | 1 | One-cycle completion pulse |
| seqCode | output | 2 | Result of the last operation |
| seqRx0 | output | 32 | First received word |
| seqRx1 | output | 32 | Second received word |

## Verification
A corrupted FIFO pointer or count shows up at the next engine pop or host data read as a word out of order. It also shows up in the status word on the very next read, as a not-empty or not-full flag that disagrees with the number of words pushed and popped. A sequencer stuck in a wait state shows as `seqBusy` staying high past the polling window, or as a wrong result code at the `seqDone` pulse. A bad compare in the exchange path gives the wrong code one cycle after the second reply word is popped. A leak of the host data port during a busy operation leaves a stray word in the inbound FIFO, and that word is visible at the engine side as soon as the operation ends.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic              pushIn;
    logic [WORD_W-1:0] pushData;
    logic              popOut;
  } seqStrobe_t;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_IOERR   = 2'd1,
    RES_TIMEOUT = 2'd2
  } seqRes_t;

  localparam logic [1:0] OP_RECV = 2'd1;
  localparam logic [1:0] OP_XCHG = 2'd2;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_MBOX = 2'd3;
endpackage

// File: rtl/msg_fifo.sv
module msg_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushEn,
  input  logic [WIDTH-1:0] pushData,
  input  logic             popEn,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign doPush = pushEn && !full;
  assign doPop  = popEn && !empty;
  assign head   = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= pushData;
        wrPtr <= nextPtr(wrPtr);
      end
      if (doPop) rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop) count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [1:0]        hostAddr,
  input  logic [WORD_W-1:0] hostWrData,
  output logic [WORD_W-1:0] hostRdData,
  input  logic              engPopEn,
  output logic [WORD_W-1:0] engPopData,
  output logic              engInEmpty,
  input  logic              engPushEn,
  input  logic [WORD_W-1:0] engPushData,
  output logic              engOutFull,
  input  logic              seqBusy,
  input  seqStrobe_t        seqStb,
  output logic              inEmpty,
  output logic              inFull,
  output logic              outEmpty,
  output logic [WORD_W-1:0] outHead
);
  // ctrlBits: [3]=bit25 [2]=bit24 [1]=bit17 [0]=bit16
  logic [3:0]  ctrlBits;
  logic [15:0] mboxReg;
  logic inEnable, outEnable, inPush, outPop, outPush, outFull, mbInt;
  logic [WORD_W-1:0] inData, statusWord, ctrlWord;

  assign inEnable  = ctrlBits[1] | ctrlBits[3];
  assign outEnable = ctrlBits[0] | ctrlBits[2];
  assign inPush  = inEnable & (seqBusy ? seqStb.pushIn
                                       : (hostWrEn && hostAddr == ADDR_DATA));
  assign inData  = seqBusy ? seqStb.pushData : hostWrData;
  assign outPop  = seqBusy ? seqStb.popOut : (hostRdEn && hostAddr == ADDR_DATA);
  assign outPush = outEnable & engPushEn;

  msg_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) inFifo_i (
    .clk(clk), .rstN(rstN), .pushEn(inPush), .pushData(inData),
    .popEn(engPopEn), .head(engPopData), .empty(inEmpty), .full(inFull));

  msg_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) outFifo_i (
    .clk(clk), .rstN(rstN), .pushEn(outPush), .pushData(engPushData),
    .popEn(outPop), .head(outHead), .empty(outEmpty), .full(outFull));

  assign engInEmpty = inEmpty;
  assign engOutFull = outFull;
  assign mbInt = |(mboxReg[7:0] & ~mboxReg[15:8]);

  always_comb begin
    statusWord = '0;
    statusWord[16] = !outEmpty;
    statusWord[17] = !inFull;
    statusWord[18] = !outFull;
    statusWord[19] = !inEmpty;
    statusWord[20] = mbInt;
    statusWord[21] = ctrlBits[3] & inEmpty;
    statusWord[22] = ctrlBits[2] & !outEmpty;
    ctrlWord = '0;
    ctrlWord[16] = ctrlBits[0];
    ctrlWord[17] = ctrlBits[1];
    ctrlWord[24] = ctrlBits[2];
    ctrlWord[25] = ctrlBits[3];
    case (hostAddr)
      ADDR_DATA: hostRdData = outEmpty ? '0 : outHead;
      ADDR_STAT: hostRdData = statusWord;
      ADDR_CTRL: hostRdData = ctrlWord;
      default:   hostRdData = {16'h0, mboxReg};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlBits <= 4'b0011;
      mboxReg  <= 16'hF0F0;
    end else if (hostWrEn) begin
      if (hostAddr == ADDR_CTRL)
        ctrlBits <= {hostWrData[25], hostWrData[24], hostWrData[17], hostWrData[16]};
      if (hostAddr == ADDR_MBOX) mboxReg <= hostWrData[15:0];
    end
  end
endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
  import mbox_pkg::*;
#(
  parameter int POLL_CYCLES = 4,
  parameter int MAX_POLLS   = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              seqStart,
  input  logic [1:0]        seqOp,
  input  logic [WORD_W-1:0] seqWord0,
  input  logic [WORD_W-1:0] seqWord1,
  input  logic              inEmpty,
  input  logic              inFull,
  input  logic              outEmpty,
  input  logic [WORD_W-1:0] outHead,
  output seqStrobe_t        seqStb,
  output logic              seqBusy,
  output logic              seqDone,
  output logic [1:0]        seqCode,
  output logic [WORD_W-1:0] seqRx0,
  output logic [WORD_W-1:0] seqRx1
);
  localparam int TW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
  localparam int PW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

  typedef enum logic [2:0] {S_IDLE, S_W0, S_W1, S_DRAIN, S_RECV} state_t;
  state_t state;
  logic [1:0] opQ;
  logic [WORD_W-1:0] tx0, tx1;
  logic rxCnt;
  logic [TW-1:0] tick;
  logic [PW-1:0] polls;
  logic pollExpire, replyBad;

  assign seqBusy    = (state != S_IDLE);
  assign pollExpire = (tick == TW'(POLL_CYCLES - 1)) && (polls == PW'(MAX_POLLS - 1));
  assign replyBad   = (opQ == OP_XCHG) && ((seqRx0 != tx0) || (outHead != tx1));

  always_comb begin
    seqStb = '0;
    case (state)
      S_W0:   if (inEmpty) begin seqStb.pushIn = 1'b1; seqStb.pushData = tx0; end
      S_W1:   if (!inFull) begin seqStb.pushIn = 1'b1; seqStb.pushData = tx1; end
      S_RECV: seqStb.popOut = !outEmpty;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; opQ <= '0; tx0 <= '0; tx1 <= '0; rxCnt <= 1'b0;
      tick <= '0; polls <= '0; seqDone <= 1'b0; seqCode <= RES_OK;
      seqRx0 <= '0; seqRx1 <= '0;
    end else begin
      seqDone <= 1'b0;
      case (state)
        S_IDLE: if (seqStart) begin
          opQ <= seqOp; tx0 <= seqWord0; tx1 <= seqWord1;
          rxCnt <= 1'b0; tick <= '0; polls <= '0;
          state <= (seqOp == OP_RECV) ? S_RECV : S_W0;
        end
        S_W0: if (!inEmpty) begin
          state <= S_IDLE; seqDone <= 1'b1; seqCode <= RES_IOERR;
        end else state <= S_W1;
        S_W1: if (inFull) begin
          state <= S_IDLE; seqDone <= 1'b1; seqCode <= RES_IOERR;
        end else state <= S_DRAIN;
        S_DRAIN: if (inEmpty) begin
          if (opQ == OP_XCHG) begin
            state <= S_RECV; tick <= '0; polls <= '0;
          end else begin
            state <= S_IDLE; seqDone <= 1'b1; seqCode <= RES_OK;
          end
        end else if (pollExpire) begin
          state <= S_IDLE; seqDone <= 1'b1; seqCode <= RES_TIMEOUT;
        end else if (tick == TW'(POLL_CYCLES - 1)) begin
          tick <= '0; polls <= polls + 1'b1;
        end else tick <= tick + 1'b1;
        S_RECV: if (!outEmpty) begin
          if (!rxCnt) begin
            seqRx0 <= outHead; rxCnt <= 1'b1;
          end else begin
            seqRx1 <= outHead; state <= S_IDLE; seqDone <= 1'b1;
            seqCode <= replyBad ? RES_IOERR : RES_OK;
          end
        end else if (pollExpire) begin
          state <= S_IDLE; seqDone <= 1'b1; seqCode <= RES_TIMEOUT;
        end else if (tick == TW'(POLL_CYCLES - 1)) begin
          tick <= '0; polls <= polls + 1'b1;
        end else tick <= tick + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msg_mailbox.sv
module msg_mailbox
  import mbox_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int POLL_CYCLES = 4,
  parameter int MAX_POLLS   = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic        hostRdEn,
  input  logic [1:0]  hostAddr,
  input  logic [31:0] hostWrData,
  output logic [31:0] hostRdData,
  input  logic        engPopEn,
  output logic [31:0] engPopData,
  output logic        engInEmpty,
  input  logic        engPushEn,
  input  logic [31:0] engPushData,
  output logic        engOutFull,
  input  logic        seqStart,
  input  logic [1:0]  seqOp,
  input  logic [31:0] seqWord0,
  input  logic [31:0] seqWord1,
  output logic        seqBusy,
  output logic        seqDone,
  output logic [1:0]  seqCode,
  output logic [31:0] seqRx0,
  output logic [31:0] seqRx1
);
  seqStrobe_t seqStb;
  logic inEmpty, inFull, outEmpty;
  logic [WORD_W-1:0] outHead;

  mbox_datapath #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .engPopEn(engPopEn), .engPopData(engPopData), .engInEmpty(engInEmpty),
    .engPushEn(engPushEn), .engPushData(engPushData), .engOutFull(engOutFull),
    .seqBusy(seqBusy), .seqStb(seqStb), .inEmpty(inEmpty), .inFull(inFull),
    .outEmpty(outEmpty), .outHead(outHead));

  mbox_seq #(.POLL_CYCLES(POLL_CYCLES), .MAX_POLLS(MAX_POLLS)) seq_i (
    .clk(clk), .rstN(rstN), .seqStart(seqStart), .seqOp(seqOp),
    .seqWord0(seqWord0), .seqWord1(seqWord1), .inEmpty(inEmpty),
    .inFull(inFull), .outEmpty(outEmpty), .outHead(outHead), .seqStb(seqStb),
    .seqBusy(seqBusy), .seqDone(seqDone), .seqCode(seqCode),
    .seqRx0(seqRx0), .seqRx1(seqRx1));
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  hostAddr,
  input logic [31:0] hostRdData,
  input logic        engInEmpty,
  input logic        engOutFull,
  input logic        seqStart,
  input logic        seqBusy,
  input logic        seqDone,
  input logic [1:0]  seqCode
);
  p_in_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddr == 2'd1) |-> (hostRdData[19] == !engInEmpty));
  p_out_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddr == 2'd1) |-> (hostRdData[18] == !engOutFull));
  p_watch_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddr == 2'd1) |-> !hostRdData[23]);
  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (seqStart && !seqBusy) |=> seqBusy);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone);
  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> !seqBusy);
  p_code_legal_r10: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> (seqCode != 2'd3));
endmodule

bind msg_mailbox mbox_checker chk_i (
  .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostRdData(hostRdData),
  .engInEmpty(engInEmpty), .engOutFull(engOutFull), .seqStart(seqStart),
  .seqBusy(seqBusy), .seqDone(seqDone), .seqCode(seqCode));

// File: tb/msg_mailbox_tb.sv
module msg_mailbox_tb_top;
  localparam int DEPTH = 4;
  localparam int POLL = 4;
  localparam int MAXP = 1000;
  localparam int WIN = POLL * MAXP;

  logic clk = 1'b0, rstN = 1'b0;
  logic hostWrEn = 0, hostRdEn = 0, engPopEn = 0, engPushEn = 0, seqStart = 0;
  logic [1:0] hostAddr = 0, seqOp = 0, seqCode;
  logic [31:0] hostWrData = 0, hostRdData, engPopData, engPushData = 0;
  logic [31:0] seqWord0 = 0, seqWord1 = 0, seqRx0, seqRx1;
  logic engInEmpty, engOutFull, seqBusy, seqDone;
  int nChk = 0, nErr = 0;
  logic [31:0] inQ[$], outQ[$];
  logic [31:0] ctrlM = 32'h00030000, mbM = 32'h0000F0F0;

  always #5 clk = ~clk;

  msg_mailbox #(.DEPTH(DEPTH), .POLL_CYCLES(POLL), .MAX_POLLS(MAXP)) dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expStatus();
    logic [31:0] s = '0;
    s[16] = outQ.size() != 0;
    s[17] = inQ.size() != DEPTH;
    s[18] = outQ.size() != DEPTH;
    s[19] = inQ.size() != 0;
    s[20] = |(mbM[7:0] & ~mbM[15:8]);
    s[21] = ctrlM[25] && inQ.size() == 0;
    s[22] = ctrlM[24] && outQ.size() != 0;
    return s;
  endfunction

  task automatic hostWrite(input logic [1:0] a, input logic [31:0] d);
    hostWrEn = 1; hostAddr = a; hostWrData = d;
    @(posedge clk); #1 hostWrEn = 0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [31:0] d);
    hostRdEn = 1; hostAddr = a; #1 d = hostRdData;
    @(posedge clk); #1 hostRdEn = 0; hostAddr = 2'd1;
  endtask

  task automatic engPop(output logic [31:0] d);
    engPopEn = 1; d = engPopData;
    @(posedge clk); #1 engPopEn = 0;
  endtask

  task automatic engPush(input logic [31:0] d);
    engPushEn = 1; engPushData = d;
    @(posedge clk); #1 engPushEn = 0;
  endtask

  task automatic runSeq(input logic [1:0] op, input logic [31:0] w0, input logic [31:0] w1,
                        output logic [1:0] code, output int cyc);
    seqStart = 1; seqOp = op; seqWord0 = w0; seqWord1 = w1;
    @(posedge clk); #1 seqStart = 0;
    cyc = 0;
    while (!seqDone && cyc < 20000) begin @(posedge clk); #1 cyc++; end
    code = seqCode;
  endtask

  task automatic chkStatus(input string tag);
    logic [31:0] v;
    hostRead(2'd1, v);
    chk(tag, v, expStatus());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++; nChk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    logic [31:0] v, e;
    logic [1:0] code;
    int cyc;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    hostAddr = 2'd1;
    // R1 reset state
    hostRead(2'd1, v); chk("R1 status", v, 32'h00060000);
    hostRead(2'd2, v); chk("R1 control", v, 32'h00030000);
    hostRead(2'd3, v); chk("R1 mailbox", v, 32'h0000F0F0);
    chk("R1 busy", {31'b0, seqBusy}, 0);

    // R2/R3/R4 random traffic on both FIFOs
    for (int i = 0; i < 200; i++) begin
      int r = $urandom % 5;
      case (r)
        0: begin v = $urandom; hostWrite(2'd0, v); if (inQ.size() < DEPTH) inQ.push_back(v); end
        1: begin engPop(v);
             if (inQ.size() != 0) begin e = inQ.pop_front(); chk("R2 inbound order", v, e); end
           end
        2: begin v = $urandom; engPush(v); if (outQ.size() < DEPTH) outQ.push_back(v); end
        3: begin hostRead(2'd0, v);
             e = (outQ.size() != 0) ? outQ.pop_front() : 32'h0;
             chk("R3 outbound read", v, e);
           end
        default: chkStatus("R4 status flags");
      endcase
    end
    // R3 overflow corner: fill past depth, then drain
    while (inQ.size() != 0) begin engPop(v); e = inQ.pop_front(); chk("R2 drain", v, e); end
    for (int k = 0; k < DEPTH + 2; k++) begin
      hostWrite(2'd0, 32'hA000 + k);
      if (inQ.size() < DEPTH) inQ.push_back(32'hA000 + k);
    end
    chkStatus("R3 full status");
    while (inQ.size() != 0) begin engPop(v); e = inQ.pop_front(); chk("R3 after overflow", v, e); end
    engPop(v); chk("R3 pop empty", {31'b0, engInEmpty}, 1);
    while (outQ.size() != 0) begin hostRead(2'd0, v); e = outQ.pop_front(); chk("R2 out drain", v, e); end

    // R5 enables
    hostWrite(2'd2, 32'h0); ctrlM = 0;
    hostWrite(2'd0, 32'h1111); engPush(32'h2222);
    chkStatus("R5 both disabled");
    hostWrite(2'd2, 32'hFFFFFFFF); ctrlM = 32'h03030000;
    hostRead(2'd2, v); chk("R5 control readback", v, 32'h03030000);
    hostWrite(2'd2, 32'h02000000); ctrlM = 32'h02000000;
    chkStatus("R7 inbound irq when empty");
    hostWrite(2'd0, 32'h3333); inQ.push_back(32'h3333);
    chkStatus("R5 inbound via bit25");
    engPop(v); chk("R5 data", v, inQ.pop_front());
    hostWrite(2'd2, 32'h01000000); ctrlM = 32'h01000000;
    engPush(32'h4444); outQ.push_back(32'h4444);
    chkStatus("R7 outbound irq");
    hostRead(2'd0, v); chk("R5 outbound via bit24", v, outQ.pop_front());
    hostWrite(2'd2, 32'h00030000); ctrlM = 32'h00030000;

    // R6 mailbox
    hostWrite(2'd3, 32'h123400F1); mbM = 32'h000000F1;
    hostRead(2'd3, v); chk("R6 mailbox write", v, 32'h000000F1);
    chkStatus("R6 mailbox irq set");
    hostWrite(2'd3, 32'h0000F0F0); mbM = 32'h0000F0F0;
    chkStatus("R6 mailbox irq clear");

    // R8 refuse when inbound not empty
    hostWrite(2'd0, 32'h5555);
    runSeq(2'd0, 32'hAAAA, 32'hBBBB, code, cyc);
    chk("R8 refuse code", {30'b0, code}, 1);
    engPop(v); chk("R8 preexisting word", v, 32'h5555);
    chk("R8 nothing pushed", {31'b0, engInEmpty}, 1);

    // R9 send OK, R13 host data port ignored while busy
    fork
      begin runSeq(2'd0, 32'hC0DE0001, 32'hC0DE0002, code, cyc); end
      begin
        repeat (4) @(posedge clk); #1;
        hostWrite(2'd0, 32'hBAD0BAD0);
        engPop(v); chk("R9 word0", v, 32'hC0DE0001);
        engPop(v); chk("R9 word1", v, 32'hC0DE0002);
      end
    join
    chk("R9 send code", {30'b0, code}, 0);
    @(posedge clk); #1 chk("R9 done pulse", {31'b0, seqDone}, 0);
    chk("R13 write ignored", {31'b0, engInEmpty}, 1);

    // R10 send timeout
    runSeq(2'd0, 32'h77, 32'h88, code, cyc);
    chk("R10 timeout code", {30'b0, code}, 2);
    chk("R10 window", (cyc >= WIN && cyc <= WIN + 4) ? 1 : 0, 1);
    engPop(v); engPop(v);

    // R11 receive OK
    engPush(32'hFACE0001); engPush(32'hFACE0002);
    runSeq(2'd1, 0, 0, code, cyc);
    chk("R11 recv code", {30'b0, code}, 0);
    chk("R11 rx0", seqRx0, 32'hFACE0001);
    chk("R11 rx1", seqRx1, 32'hFACE0002);
    // R11 receive timeout with one word
    engPush(32'h99);
    runSeq(2'd1, 0, 0, code, cyc);
    chk("R11 recv timeout", {30'b0, code}, 2);
    chk("R11 window", (cyc >= WIN && cyc <= WIN + 4) ? 1 : 0, 1);
    chkStatus("R11 word consumed");

    // R12 exchange match and mismatch
    for (int m = 0; m < 2; m++) begin
      fork
        begin runSeq(2'd2, 32'h10 + m, 32'h20 + m, code, cyc); end
        begin
          logic [31:0] a, b;
          repeat (5) @(posedge clk); #1;
          engPop(a); engPop(b);
          engPush(a); engPush(m == 0 ? b : b ^ 32'h1);
        end
      join
      chk(m == 0 ? "R12 exchange match" : "R12 exchange mismatch", {30'b0, code}, m);
    end

    $display("  Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule